// File: doc/BRIEF.md
# Auto-Reload Periodic Tick Timer

This block produces a regular one-clock tick whose spacing is set by a programmable value. A rising edge on the `arm` input makes the block capture `reload_val`. That value goes into both a down-counter and a stored period register. The counter then steps down once per clock. When it reaches zero, `tick` is high for that clock, and on the next clock the counter restarts from the stored period. The stored period is reused every cycle of the count until `arm` rises again.

A typical use is to drive the enable of a separate up-counter with `tick`, so that the programmed value sets how fast that counter advances. `reload_val` is assumed to be in the clock domain of the block and stable before `arm` rises. No synchronisation is applied to it.

Top module: `periodic_tick_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter and the stored period are set to all ones. `tick` is low after reset. With `arm` kept low, the first tick comes 2^WIDTH-1 clocks after reset is released, and the tick then repeats every 2^WIDTH clocks.
- R2: A load happens only on a clock edge where `arm` is 1 and was 0 at the previous edge. Keeping `arm` high never causes a second load.
- R3: At a load edge, both the counter and the stored period take `reload_val`. With value N, `tick` is first high in the clock N edges after the load edge.
- R4: Without a load, a nonzero counter decrements by one per clock, and a zero counter is refilled from the stored period at the next edge. As a result, `tick` repeats every N+1 clocks.
- R5: With a stored value of 0, `tick` stays high on every clock after the load.
- R6: A load has priority over the refill at zero and over the decrement. An `arm` edge taken while the counter is zero restarts the count from the new `reload_val`.
- R7: With a stored value N of at least 1, every `tick` pulse lasts exactly one clock.
- R8: The edge detector resets to 0. If `arm` is already high when reset is released, exactly one load happens at the first edge after the release.
- R9: Changes on `reload_val` at edges without a load have no effect on the tick pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arm | input | 1 | Level input; its 0-to-1 transition requests a load |
| reload_val | input | WIDTH | Period value captured at a load |
| tick | output | 1 | High for each clock in which the counter is zero |

## Verification
The hardest situation to reach from the ports is a new `arm` edge that arrives in exactly the clock where the counter is zero. Only that timing shows whether the load beats the refill. The stimulus first loads a known value and drops `arm`, then counts clocks to the predicted tick. It raises `arm` with a different value in that tick clock and checks the shorter spacing that follows. A second hard case is `arm` held high across the release of reset. This is reached by keeping `arm` high during reset and checking that the first tick and every later one follow the captured value, with no extra restart.

// File: rtl/tick_timer_pkg.sv
// Shared definitions for the periodic tick timer.
// Assumes: nothing beyond IEEE 1800-2017.
package tick_timer_pkg;

    // Action the down-counter takes at the next clock edge.
    typedef enum logic [1:0] {
        CNT_OP_LOAD   = 2'd0,
        CNT_OP_REFILL = 2'd1,
        CNT_OP_STEP   = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/arm_edge_pulse.sv
// Turns the arm level into a single-clock load pulse on its 0-to-1
// transition. The history bit resets to 0, so a level that is already high
// when reset is released gives one pulse.
// Assumes: level_in is synchronous to clk.
module arm_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic pulse_out
);

    logic level_prev_q;

    // Purpose: remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_prev_q <= 1'b0;
        end else begin
            level_prev_q <= level_in;
        end
    end

    // Purpose: combine the present and previous levels into the pulse.
    always_comb begin
        pulse_out = level_in & ~level_prev_q;
    end

endmodule

// File: rtl/period_store.sv
// Holds the period value captured at the last load. It is reused for every
// refill until the next load.
// Assumes: capture is a single-clock pulse; din is stable when it is high.
module period_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] period
);

    localparam logic [WIDTH-1:0] RESET_PERIOD = {WIDTH{1'b1}};

    logic [WIDTH-1:0] period_q;

    // Purpose: capture the period on a load; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= RESET_PERIOD;
        end else if (capture) begin
            period_q <= din;
        end
    end

    assign period = period_q;

endmodule

// File: rtl/countdown_core.sv
// Down-counter with load, refill-at-zero and step actions, in that order of
// priority. at_zero decodes the counter state for the whole clock.
// Assumes: load is a single-clock pulse.
module countdown_core
    import tick_timer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] refill_val,
    output logic [WIDTH-1:0] count,
    output logic             at_zero
);

    localparam logic [WIDTH-1:0] RESET_COUNT = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO_COUNT  = {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] ONE_STEP    = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_next;
    cnt_op_e          op_sel;

    // Purpose: pick the action for the next edge, with load first.
    always_comb begin
        if (load) begin
            op_sel = CNT_OP_LOAD;
        end else if (count_q == ZERO_COUNT) begin
            op_sel = CNT_OP_REFILL;
        end else begin
            op_sel = CNT_OP_STEP;
        end
    end

    // Purpose: form the next counter value from the chosen action.
    always_comb begin
        unique case (op_sel)
            CNT_OP_LOAD:   count_next = load_val;
            CNT_OP_REFILL: count_next = refill_val;
            default:       count_next = count_q - ONE_STEP;
        endcase
    end

    // Purpose: the counter register with synchronous reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RESET_COUNT;
        end else begin
            count_q <= count_next;
        end
    end

    assign count   = count_q;
    assign at_zero = (count_q == ZERO_COUNT);

endmodule

// File: rtl/periodic_tick_timer.sv
// Programmable periodic tick generator. An arm edge loads reload_val. The
// tick is high once every (value + 1) clocks, and every clock for value 0.
// Assumes: reload_val is synchronous and stable before arm rises.
module periodic_tick_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [WIDTH-1:0] reload_val,
    output logic             tick
);

    logic             load_pulse;
    logic [WIDTH-1:0] period_q;
    logic [WIDTH-1:0] count_q;

    arm_edge_pulse u_arm_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (arm),
        .pulse_out (load_pulse)
    );

    period_store #(
        .WIDTH (WIDTH)
    ) u_period_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (load_pulse),
        .din     (reload_val),
        .period  (period_q)
    );

    countdown_core #(
        .WIDTH (WIDTH)
    ) u_countdown (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_pulse),
        .load_val   (reload_val),
        .refill_val (period_q),
        .count      (count_q),
        .at_zero    (tick)
    );

endmodule

// File: rtl/periodic_tick_timer_chk.sv
// Property checker for periodic_tick_timer, attached through bind.
// Assumes: it observes the load pulse, counter and stored period of the top.
module periodic_tick_timer_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count,
    input logic [WIDTH-1:0] period,
    input logic             tick
);

    localparam logic [WIDTH-1:0] ZERO_VAL = {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] ONE_VAL  = {{(WIDTH-1){1'b0}}, 1'b1};

    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load); // R2

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(din)) && (period == $past(din))); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count != ZERO_VAL) |=> count == $past(count) - ONE_VAL); // R4

    AST_REFILL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == ZERO_VAL) |=> count == $past(period)); // R4

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && period != ZERO_VAL) |=> !tick); // R7

    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(period)); // R9

endmodule

bind periodic_tick_timer periodic_tick_timer_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_pulse),
    .din    (reload_val),
    .count  (count_q),
    .period (period_q),
    .tick   (tick)
);

// File: tb/test_periodic_tick_timer.sv
// Scoreboard bench for periodic_tick_timer. Driver tasks push the expected
// tick value for each clock into a queue. A monitor on the falling edge pops
// each item and compares it with the port.
module test_periodic_tick_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 8;
    localparam int FULL_SPAN  = 1 << WIDTH;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic [WIDTH-1:0] reload_val = '0;
    logic             tick;

    int checks = 0;
    int bad    = 0;
    bit done_flag = 1'b0;

    bit    exp_q[$];
    bit    care_q[$];
    string tag_q[$];

    periodic_tick_timer #(.WIDTH(WIDTH)) i_periodic_tick_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .reload_val (reload_val),
        .tick       (tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare one expected item per clock, mid-cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit    e;
            bit    c;
            string t;
            e = exp_q.pop_front();
            c = care_q.pop_front();
            t = tag_q.pop_front();
            if (c) begin
                checks++;
                if (tick !== e) begin
                    bad++;
                    $display("FAIL %s: tick actual=%b expected=%b at %0t", t, tick, e, $time);
                end
            end
        end
    end

    // Driver step: after an edge, push the expectation for this clock and
    // set the inputs that the next edge will sample.
    task automatic step(input bit care, input bit exp, input bit rst_v,
                        input bit arm_v, input logic [WIDTH-1:0] d_v,
                        input string tag);
        @(posedge clk);
        #1;
        exp_q.push_back(exp);
        care_q.push_back(care);
        tag_q.push_back(tag);
        rst_n      = rst_v;
        arm        = arm_v;
        reload_val = d_v;
    endtask

    // Watch len clocks after a load of value n. Clock i after the load edge
    // ticks when i mod (n+1) == n. reload_val is scrambled to check R9.
    task automatic watch(input int n, input int len, input bit keep_arm,
                         input string tag);
        for (int i = 0; i < len; i++) begin
            step(1'b1, (i % (n + 1)) == n, 1'b1, keep_arm,
                 WIDTH'((i * 37 + 11) & 8'hff), tag);
        end
    endtask

    initial begin
        // Reset held for a few clocks: tick low (R1).
        for (int i = 0; i < 3; i++) begin
            step(i > 0, 1'b0, 1'b0, 1'b0, '0, "R1 reset");
        end
        // Release reset with arm low. After m free-run edges the counter holds
        // all-ones minus m, so tick when m mod 2^WIDTH == 2^WIDTH-1 (R1).
        step(1'b1, 1'b0, 1'b1, 1'b0, '0, "R1 release");
        for (int m = 1; m <= FULL_SPAN + 40; m++) begin
            step(1'b1, (m % FULL_SPAN) == FULL_SPAN - 1, 1'b1, 1'b0,
                 WIDTH'(m), "R1 free run");
        end

        // Load 3 and keep arm high while reload_val wanders: period 4 (R2 R3 R4 R7 R9).
        step(1'b0, 1'b0, 1'b1, 1'b1, WIDTH'(3), "R3");
        watch(3, 24, 1'b1, "R2 R3 R4 R7 R9 n=3");

        // Drop arm for one edge, then load 0: tick every clock (R5).
        step(1'b0, 1'b0, 1'b1, 1'b0, '0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b1, '0, "R5");
        watch(0, 12, 1'b0, "R5 n=0");

        // Load 1: period 2.
        step(1'b0, 1'b0, 1'b1, 1'b1, WIDTH'(1), "R4");
        watch(1, 10, 1'b0, "R4 R7 n=1");

        // Load 9: period 10.
        step(1'b0, 1'b0, 1'b1, 1'b1, WIDTH'(9), "R4");
        watch(9, 35, 1'b0, "R4 R7 n=9");

        // Priority (R6): load 4, then raise arm with 2 in the tick clock.
        step(1'b0, 1'b0, 1'b1, 1'b1, WIDTH'(4), "R6");
        watch(4, 4, 1'b0, "R6 pre n=4");
        step(1'b1, 1'b1, 1'b1, 1'b1, WIDTH'(2), "R6 zero clock");
        watch(2, 12, 1'b1, "R6 restart n=2");

        // Arm high through reset (R8): one load at the first edge after release.
        step(1'b0, 1'b0, 1'b0, 1'b1, WIDTH'(5), "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, WIDTH'(5), "R8 in reset");
        step(1'b1, 1'b0, 1'b1, 1'b1, WIDTH'(5), "R8 release");
        watch(5, 26, 1'b1, "R8 n=5");

        step(1'b0, 1'b0, 1'b1, 1'b0, '0, "end");
        @(posedge clk);
        @(negedge clk);
        #1;
        done_flag = 1'b1;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        int cyc;
        cyc = 0;
        while (!done_flag && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done_flag) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WATCHDOG);
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule